// File: doc/BRIEF.md
# Toroidal Three-Axis Data Shift Lattice

This block is the routing fabric of a box of processing elements arranged as columns × rows × layers. Each element position holds one data register. A multiplexer in front of that register picks its next value. A single control code, shared by every position, sets the source for all of them at once: the neighbour one column to the west, the neighbour one row below, the neighbour one layer below, or the register's own value. All three axes wrap around. As a result, each shift moves the whole box as a circular rotation along one axis.

The mesh reaches the outside world only at its west and east faces, and only while the refresh control is high. During refresh the fabric always shifts east. Column 0 takes fresh words from the external input lanes, and the easternmost column presents its words on the external output lanes. New data therefore enters while results leave in the same cycles. When refresh is low, the output lanes read zero and the input lanes have no effect. Each row/layer pair forms one lane, numbered `lane = layer*ROWS + row`. Lane `k` occupies bits `[k*W +: W]` of both external buses.

Top module: `lattice_mesh3d`

## Requirements
- R1: While reset is asserted, and after it is released, every element register holds zero and `ext_out` is all zeros.
- R2: With refresh low and `axis_sel` = 0 (east/west), each element at column c loads the value from column c-1 of the same row and layer, and column 0 loads from column COLS-1.
- R3: With refresh low and `axis_sel` = 1 (north/south), each element at row r loads from row r-1 of the same column and layer, and row 0 loads from row ROWS-1.
- R4: With refresh low and `axis_sel` = 2 (layer), each element at layer l loads from layer l-1 of the same column and row, and layer 0 loads from layer LAYERS-1.
- R5: With refresh low and `axis_sel` = 3 (hold), every element register keeps its value.
- R6: Shifts without refresh only permute data. COLS east/west shifts, ROWS north/south shifts or LAYERS layer shifts each return the box to its starting contents.
- R7: With refresh high, `axis_sel` is ignored and the box shifts east. Column 0 of lane k loads the full W-bit word `ext_in[k*W +: W]` instead of the wraparound value.
- R8: With refresh high, `ext_out[k*W +: W]` shows the current column COLS-1 register of lane k, combinationally. A word fed in on a refresh cycle therefore appears on `ext_out` exactly COLS refresh cycles later.
- R9: With refresh low, `ext_out` is all zeros and `ext_in` has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all element registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| axis_sel | input | 2 | Shared source code: 0 east/west, 1 north/south, 2 layer, 3 hold |
| refresh | input | 1 | Opens the boundary ports and forces an eastward shift |
| ext_in | input | ROWS*LAYERS*W | West-face input lanes, lane k at bits [k*W +: W] |
| ext_out | output | ROWS*LAYERS*W | East-face output lanes, zero unless refresh is high |

## Verification
Every shift takes effect at the first rising edge after the control is applied, so a register change is due one cycle later. `ext_out` is combinational from the column COLS-1 registers and the refresh input, so it is due in the same cycle. The bench applies each control at a falling edge, compares `ext_out` a moment later against a model of the box state, and only then advances the model by one shift. The internal state is observed through refresh passes. During a pass of COLS cycles, the output in cycle k is the word that sat in column COLS-1-k before the pass began, and a new load pattern enters at the same time.

// File: rtl/lattice_pkg.sv
package lattice_pkg;

  typedef enum logic [1:0] {
    AX_EW    = 2'd0,
    AX_NS    = 2'd1,
    AX_LAYER = 2'd2,
    AX_HOLD  = 2'd3
  } axis_e;

  // predecessor on a ring of n positions
  function automatic int ring_prev(input int p, input int n);
    return (p == 0) ? n - 1 : p - 1;
  endfunction

  // boundary lane number of a row/layer pair
  function automatic int lane_of(input int r, input int l, input int rows);
    return l * rows + r;
  endfunction

  // flat position of an element
  function automatic int cell_of(input int c, input int r, input int l,
                                 input int cols, input int rows);
    return (l * rows + r) * cols + c;
  endfunction

endpackage

// File: rtl/lattice_cell.sv
module lattice_cell #(
  parameter int W = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  lattice_pkg::axis_e  sel,
  input  logic [W-1:0]        from_west,
  input  logic [W-1:0]        from_south,
  input  logic [W-1:0]        from_below,
  output logic [W-1:0]        q
);
  import lattice_pkg::*;

  logic [W-1:0] nxt;

  always_comb begin
    unique case (sel)
      AX_EW:    nxt = from_west;
      AX_NS:    nxt = from_south;
      AX_LAYER: nxt = from_below;
      default:  nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

endmodule

// File: rtl/lattice_edge_port.sv
module lattice_edge_port #(
  parameter int W = 18
) (
  input  logic         refresh,
  input  logic [W-1:0] lane_in,
  input  logic [W-1:0] east_q,
  output logic [W-1:0] west_feed,
  output logic [W-1:0] lane_out
);
  // the west face takes outside data only while refresh is open
  assign west_feed = refresh ? lane_in : east_q;
  // the east face is closed (zero) outside refresh
  assign lane_out  = refresh ? east_q : '0;
endmodule

// File: rtl/lattice_mesh3d.sv
module lattice_mesh3d #(
  parameter int COLS   = 4,
  parameter int ROWS   = 3,
  parameter int LAYERS = 2,
  parameter int W      = 18
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   axis_sel,
  input  logic                         refresh,
  input  logic [ROWS*LAYERS*W-1:0]     ext_in,
  output logic [ROWS*LAYERS*W-1:0]     ext_out
);
  import lattice_pkg::*;

  localparam int LANES = ROWS * LAYERS;
  localparam int CELLS = COLS * LANES;

  logic [W-1:0]         cell_q    [CELLS];
  logic [W-1:0]         col0_feed [LANES];
  logic [CELLS*W-1:0]   state_flat;   // observation point for the checker
  axis_e                eff_axis;     // refresh overrides the shared code

  always_comb eff_axis = refresh ? AX_EW : axis_e'(axis_sel);

  // boundary lanes
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int LR   = k % ROWS;
    localparam int LL   = k / ROWS;
    localparam int EAST = cell_of(COLS - 1, LR, LL, COLS, ROWS);
    lattice_edge_port #(.W(W)) u_edge (
      .refresh   (refresh),
      .lane_in   (ext_in[k*W +: W]),
      .east_q    (cell_q[EAST]),
      .west_feed (col0_feed[k]),
      .lane_out  (ext_out[k*W +: W])
    );
  end

  // element array with toroidal links
  for (genvar l = 0; l < LAYERS; l++) begin : g_layer
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
        localparam int ME  = cell_of(c, r, l, COLS, ROWS);
        localparam int WN  = cell_of(ring_prev(c, COLS), r, l, COLS, ROWS);
        localparam int SN  = cell_of(c, ring_prev(r, ROWS), l, COLS, ROWS);
        localparam int BN  = cell_of(c, r, ring_prev(l, LAYERS), COLS, ROWS);
        localparam int LN  = lane_of(r, l, ROWS);
        logic [W-1:0] west_src;
        if (c == 0) begin : g_edge
          assign west_src = col0_feed[LN];
        end else begin : g_inner
          assign west_src = cell_q[WN];
        end
        lattice_cell #(.W(W)) u_cell (
          .clk        (clk),
          .rst_n      (rst_n),
          .sel        (eff_axis),
          .from_west  (west_src),
          .from_south (cell_q[SN]),
          .from_below (cell_q[BN]),
          .q          (cell_q[ME])
        );
        assign state_flat[ME*W +: W] = cell_q[ME];
      end
    end
  end

endmodule

// File: rtl/lattice_mesh3d_chk.sv
module lattice_mesh3d_chk #(
  parameter int COLS   = 4,
  parameter int ROWS   = 3,
  parameter int LAYERS = 2,
  parameter int W      = 18
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [1:0]                   axis_sel,
  input logic                         refresh,
  input logic [ROWS*LAYERS*W-1:0]     ext_in,
  input logic [ROWS*LAYERS*W-1:0]     ext_out,
  input logic [COLS*ROWS*LAYERS*W-1:0] state_flat
);
  import lattice_pkg::*;

  // R9: east face closed outside refresh
  p_out_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh |-> ext_out == '0);

  // R5: hold code freezes the box
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!refresh && axis_sel == 2'd3) |=> $stable(state_flat));

  // R6: rotation without refresh neither loses nor invents bits
  p_perm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh |=> $countones(state_flat) == $countones($past(state_flat)));

  for (genvar l = 0; l < LAYERS; l++) begin : g_l
    for (genvar r = 0; r < ROWS; r++) begin : g_r
      localparam int K  = lane_of(r, l, ROWS);
      localparam int C0 = cell_of(0, r, l, COLS, ROWS);
      localparam int CE = cell_of(COLS - 1, r, l, COLS, ROWS);
      localparam int R0 = cell_of(0, 0, l, COLS, ROWS);
      localparam int L0 = cell_of(0, r, 0, COLS, ROWS);
      localparam int RT = cell_of(0, ROWS - 1, l, COLS, ROWS);
      localparam int LT = cell_of(0, r, LAYERS - 1, COLS, ROWS);

      // R2: east/west wraparound
      p_ew_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!refresh && axis_sel == 2'd0) |=>
          state_flat[C0*W +: W] == $past(state_flat[CE*W +: W]));

      // R3: north/south wraparound (checked on column 0)
      p_ns_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!refresh && axis_sel == 2'd1) |=>
          state_flat[R0*W +: W] == $past(state_flat[RT*W +: W]));

      // R4: layer wraparound (checked on column 0)
      p_layer_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!refresh && axis_sel == 2'd2) |=>
          state_flat[L0*W +: W] == $past(state_flat[LT*W +: W]));

      // R7: refresh loads column 0 from the lane
      p_refresh_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> state_flat[C0*W +: W] == $past(ext_in[K*W +: W]));

      if (COLS > 1) begin : g_adv
        localparam int C1 = cell_of(1, r, l, COLS, ROWS);
        // R7: refresh shifts east whatever axis_sel says
        p_refresh_east_r7: assert property (@(posedge clk) disable iff (!rst_n)
          refresh |=> state_flat[C1*W +: W] == $past(state_flat[C0*W +: W]));
      end
    end
  end

endmodule

bind lattice_mesh3d lattice_mesh3d_chk #(
  .COLS(COLS), .ROWS(ROWS), .LAYERS(LAYERS), .W(W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .axis_sel   (axis_sel),
  .refresh    (refresh),
  .ext_in     (ext_in),
  .ext_out    (ext_out),
  .state_flat (state_flat)
);

// File: tb/lattice_mesh3d_tb_top.sv
module lattice_mesh3d_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int COLS   = 4;
  localparam int ROWS   = 3;
  localparam int LAYERS = 2;
  localparam int W      = 18;
  localparam int LANES  = ROWS * LAYERS;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [1:0]           axis_sel;
  logic                 refresh;
  logic [LANES*W-1:0]   ext_in;
  logic [LANES*W-1:0]   ext_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench copy of the box contents
  logic [W-1:0] m [COLS][ROWS][LAYERS];

  always #(CLK_PERIOD/2) clk = ~clk;

  lattice_mesh3d #(.COLS(COLS), .ROWS(ROWS), .LAYERS(LAYERS), .W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .axis_sel(axis_sel), .refresh(refresh),
    .ext_in(ext_in), .ext_out(ext_out)
  );

  function automatic logic [W-1:0] pat(input int seed, input int c, input int r, input int l);
    return {6'(seed), 4'(c), 4'(r), 4'(l)};
  endfunction

  // one clock of stimulus: check ext_out now, then advance the model
  task automatic step(input logic [1:0] ax, input logic rf,
                      input logic [LANES*W-1:0] din, input string tag);
    logic [LANES*W-1:0] exp_out;
    logic [W-1:0] nm [COLS][ROWS][LAYERS];
    string t;
    @(negedge clk);
    axis_sel = ax; refresh = rf; ext_in = din;
    #1;
    exp_out = '0;
    for (int l = 0; l < LAYERS; l++)
      for (int r = 0; r < ROWS; r++)
        if (rf) exp_out[(l*ROWS+r)*W +: W] = m[COLS-1][r][l];
    t = rf ? tag : "R9";
    checks++;
    if (ext_out !== exp_out) begin
      fails++;
      $display("FAIL %s: ext_out actual %h expected %h", t, ext_out, exp_out);
    end
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++)
        for (int l = 0; l < LAYERS; l++) begin
          if (rf || ax == 2'd0) begin
            if (c == 0) nm[c][r][l] = rf ? din[(l*ROWS+r)*W +: W] : m[COLS-1][r][l];
            else        nm[c][r][l] = m[c-1][r][l];
          end else if (ax == 2'd1) nm[c][r][l] = m[c][(r+ROWS-1)%ROWS][l];
          else if (ax == 2'd2)     nm[c][r][l] = m[c][r][(l+LAYERS-1)%LAYERS];
          else                     nm[c][r][l] = m[c][r][l];
        end
    m = nm;
  endtask

  // refresh pass: reads the box out (checked per cycle) while loading a pattern
  task automatic refresh_pass(input int seed, input logic [1:0] ax,
                              input bit extremes, input string tag);
    logic [LANES*W-1:0] v;
    for (int k = 0; k < COLS; k++) begin
      for (int l = 0; l < LAYERS; l++)
        for (int r = 0; r < ROWS; r++)
          if (extremes) v[(l*ROWS+r)*W +: W] = ((l*ROWS+r+k) % 2 == 1) ? {W{1'b1}} : '0;
          else          v[(l*ROWS+r)*W +: W] = pat(seed, COLS-1-k, r, l);
      step(ax, 1'b1, v, tag);
    end
  endtask

  task automatic t_reset;
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++)
        for (int l = 0; l < LAYERS; l++) m[c][r][l] = '0;
    step(2'd3, 1'b0, {LANES{18'h2AAAA}}, "R1");
    step(2'd0, 1'b0, {LANES{18'h15555}}, "R1");
    refresh_pass(1, 2'd0, 1'b0, "R1");   // R1: zeros come out, pattern 1 goes in
  endtask

  task automatic t_latency;               // R8: pattern 1 emerges COLS cycles later
    refresh_pass(2, 2'd0, 1'b0, "R8");
  endtask

  task automatic t_ew;                    // R2
    step(2'd0, 1'b0, {LANES{18'h3FFFF}}, "R2");
    refresh_pass(3, 2'd0, 1'b0, "R2");
  endtask

  task automatic t_ns;                    // R3
    step(2'd1, 1'b0, '0, "R3");
    step(2'd1, 1'b0, '0, "R3");
    refresh_pass(4, 2'd0, 1'b0, "R3");
  endtask

  task automatic t_layer;                 // R4
    step(2'd2, 1'b0, {LANES{18'h00001}}, "R4");
    refresh_pass(5, 2'd0, 1'b0, "R4");
  endtask

  task automatic t_hold;                  // R5, R9: ext_in noise ignored
    for (int i = 0; i < 3; i++) step(2'd3, 1'b0, {LANES{18'h3C3C3}}, "R5");
    refresh_pass(6, 2'd0, 1'b0, "R5");
  endtask

  task automatic t_full_turn;             // R6
    for (int i = 0; i < COLS; i++)   step(2'd0, 1'b0, '1, "R6");
    for (int i = 0; i < ROWS; i++)   step(2'd1, 1'b0, '1, "R6");
    for (int i = 0; i < LAYERS; i++) step(2'd2, 1'b0, '1, "R6");
    refresh_pass(7, 2'd0, 1'b0, "R6");
  endtask

  task automatic t_refresh_axis;          // R7: axis_sel ignored, full-width words
    refresh_pass(8, 2'd1, 1'b0, "R7");
    refresh_pass(9, 2'd3, 1'b1, "R7");
    refresh_pass(10, 2'd2, 1'b0, "R7");
    refresh_pass(11, 2'd0, 1'b0, "R7");
  endtask

  initial begin
    rst_n = 1'b0; axis_sel = 2'd3; refresh = 1'b0; ext_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;                               // R1: outputs quiet during reset
    if (ext_out !== '0) begin
      fails++;
      $display("FAIL R1: ext_out in reset actual %h expected 0", ext_out);
    end
    rst_n = 1'b1;
    t_reset();
    t_latency();
    t_ew();
    t_ns();
    t_layer();
    t_hold();
    t_full_turn();
    t_refresh_axis();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule